// File: doc/BRIEF.md
# DRAM Refresh and Power-Mode Sequencer

This block tracks the refresh and power state of a cached DRAM device. The device's control pins are sampled on the system clock. When the row strobe is seen falling while the refresh pin is low, the block runs one refresh at the row held in its internal counter and then advances the counter. A separate strobe pattern puts the device into self-refresh. In that mode an internal tick keeps issuing refreshes from the same counter until the row strobe returns high. A recovery time follows the exit.

After reset the block requires a start-up sequence before it raises `ready`. The row strobe must first stay high for an idle time. Then eight counter-based refreshes must run, along with two reads to different rows. Once the device is ready, a window monitor checks that every scaled refresh window contains enough refreshes. A sticky error flag records any access made too early. All timing is expressed as parameters in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: A falling row strobe with the refresh pin low, once accepted, raises `refresh_pulse` for exactly one cycle, starting the cycle after the strobe edge is sampled. During that pulse, `refresh_row` shows the counter value, and the counter then advances by one.
- R2: A refresh request is accepted whether chip select is high or low. A read or write request made with chip select high is ignored: it produces no pulse, no init progress and no error.
- R3: The row counter is ROW_W bits wide. It wraps from its all-ones value back to zero.
- R4: Self-refresh is entered on a row-strobe fall with chip select, write select, refresh pin and write enable all high and the column strobe low. `self_refresh_on` rises the next cycle. It stays high until the row strobe is sampled high, and it clears in that same cycle.
- R5: In self-refresh, a refresh pulse is issued from the shared counter every SR_TICK cycles. Over N self-refresh cycles this gives floor((N-1)/SR_TICK) pulses.
- R6: For RECOV_CYC cycles after self-refresh ends, every row-strobe fall is ignored.
- R7: Until the row strobe has been sampled high for IDLE_CYC consecutive cycles after reset, every row-strobe fall is ignored. Any such fall restarts the idle count.
- R8: `ready` rises after eight accepted pin refreshes and two accepted reads to different row addresses. A repeated read of the same row does not count. Once high, `ready` stays high.
- R9: `seq_error` becomes set, and stays set, on a selected write request made before `ready`, or on a selected read request made before the idle time completes. Reads during the init phase and writes after `ready` do not set it.
- R10: Once `ready` is high, `window_viol` becomes set, and stays set, when a WIN_CYC-cycle window closes with fewer than MIN_REF refresh pulses.
- R11: `standby` equals the chip-select level sampled on the previous edge. It is forced low while in self-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_stb_n | input | 1 | Row strobe, active low |
| chip_sel_n | input | 1 | Chip select, active low |
| write_sel | input | 1 | High selects write, low selects read |
| refresh_n | input | 1 | Refresh request pin, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| row_addr | input | ROW_W | Row address presented at the strobe fall |
| refresh_row | output | ROW_W | Row of the most recent refresh |
| refresh_pulse | output | 1 | One-cycle strobe per refresh |
| self_refresh_on | output | 1 | Self-refresh mode active |
| ready | output | 1 | Initialization complete |
| seq_error | output | 1 | Sticky early-access error |
| window_viol | output | 1 | Sticky refresh-window violation |
| standby | output | 1 | Low-power standby state |

## Verification
The bench builds the block with a 4-bit row counter. This lets the wrap from 15 to 0 occur several times during the random phase. It uses a 20-cycle idle time, an 8-cycle self-refresh tick, a 6-cycle recovery time, and a 400-cycle window that needs 4 refreshes. With these values, the start-up sequence, a multi-tick self-refresh stay with its recovery, and both a met window and a starved window all fit into a few thousand cycles. Separate resets isolate the sticky error cases.

// File: rtl/dram_rfsq_pkg.sv
package dram_rfsq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INIT  = 2'd1,
    ST_READY = 2'd2
  } init_st_e;

  typedef struct packed {
    logic ref_req;
    logic rd_req;
    logic wr_req;
    logic sr_req;
  } strobe_cmd_t;
endpackage

// File: rtl/dram_rfsq_decode.sv
module dram_rfsq_decode
  import dram_rfsq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        row_stb_n,
  input  logic        chip_sel_n,
  input  logic        write_sel,
  input  logic        refresh_n,
  input  logic        col_stb_n,
  input  logic        wr_en_n,
  output strobe_cmd_t cmd,
  output logic        stby_q
);
  logic stb_prev;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev <= 1'b1;
      stby_q   <= 1'b0;
    end else begin
      stb_prev <= row_stb_n;
      stby_q   <= chip_sel_n;
    end
  end

  assign fall = stb_prev & ~row_stb_n;

  always_comb begin
    cmd.ref_req = fall & ~refresh_n;
    cmd.rd_req  = fall & refresh_n & ~chip_sel_n & ~write_sel;
    cmd.wr_req  = fall & refresh_n & ~chip_sel_n & write_sel & col_stb_n;
    cmd.sr_req  = fall & refresh_n & chip_sel_n & write_sel & wr_en_n & ~col_stb_n;
  end
endmodule

// File: rtl/dram_rfsq_init.sv
module dram_rfsq_init
  import dram_rfsq_pkg::*;
#(
  parameter int ROW_W    = 11,
  parameter int IDLE_CYC = 20,
  parameter int INIT_REF = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_stb_n,
  input  logic             ref_ok,
  input  logic             rd_ok,
  input  logic             rd_req,
  input  logic             wr_req,
  input  logic [ROW_W-1:0] rd_row,
  output logic             idle_done,
  output logic             ready,
  output logic             seq_err
);
  localparam int IDLE_W = $clog2(IDLE_CYC + 1);
  localparam int REF_W  = $clog2(INIT_REF + 1);

  init_st_e         st_q, st_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic [REF_W-1:0]  refs_q, refs_d;
  logic [ROW_W-1:0]  row1_q, row1_d;
  logic              row1_vld_q, row1_vld_d;
  logic              rows_ok_q, rows_ok_d;
  logic              err_q, err_d;

  always_comb begin
    st_d       = st_q;
    idle_d     = idle_q;
    refs_d     = refs_q;
    row1_d     = row1_q;
    row1_vld_d = row1_vld_q;
    rows_ok_d  = rows_ok_q;
    case (st_q)
      ST_IDLE: begin
        if (row_stb_n) begin
          if (idle_q == IDLE_W'(IDLE_CYC - 1)) st_d = ST_INIT;
          else idle_d = idle_q + 1'b1;
        end else begin
          idle_d = '0;
        end
      end
      ST_INIT: begin
        if (ref_ok && refs_q != REF_W'(INIT_REF)) refs_d = refs_q + 1'b1;
        if (rd_ok) begin
          if (!row1_vld_q) begin
            row1_vld_d = 1'b1;
            row1_d     = rd_row;
          end else if (rd_row != row1_q) begin
            rows_ok_d = 1'b1;
          end
        end
        if (refs_d == REF_W'(INIT_REF) && rows_ok_d) st_d = ST_READY;
      end
      default: st_d = ST_READY;
    endcase
    err_d = err_q | (wr_req & (st_q != ST_READY)) | (rd_req & (st_q == ST_IDLE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      idle_q     <= '0;
      refs_q     <= '0;
      row1_q     <= '0;
      row1_vld_q <= 1'b0;
      rows_ok_q  <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      st_q       <= st_d;
      idle_q     <= idle_d;
      refs_q     <= refs_d;
      row1_q     <= row1_d;
      row1_vld_q <= row1_vld_d;
      rows_ok_q  <= rows_ok_d;
      err_q      <= err_d;
    end
  end

  assign idle_done = (st_q != ST_IDLE);
  assign ready     = (st_q == ST_READY);
  assign seq_err   = err_q;
endmodule

// File: rtl/dram_rfsq_refresh.sv
module dram_rfsq_refresh #(
  parameter int ROW_W     = 11,
  parameter int SR_TICK   = 8,
  parameter int RECOV_CYC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_stb_n,
  input  logic             ref_req,
  input  logic             sr_req,
  input  logic             idle_done,
  output logic             pin_ack,
  output logic             busy,
  output logic             sr_on,
  output logic             pulse,
  output logic [ROW_W-1:0] row
);
  localparam int TICK_W = (SR_TICK > 2) ? $clog2(SR_TICK) : 1;
  localparam int REC_W  = $clog2(RECOV_CYC + 1);

  logic [ROW_W-1:0]  cnt_q, cnt_d, row_q, row_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic [REC_W-1:0]  rec_q, rec_d;
  logic              sr_q, sr_d, pulse_q;
  logic              accept, sr_go, go;

  always_comb begin
    accept  = idle_done & ~sr_q & (rec_q == '0);
    pin_ack = ref_req & accept;
    sr_go   = sr_q & ~row_stb_n & (tick_q == TICK_W'(SR_TICK - 1));
    go      = pin_ack | sr_go;
    sr_d    = sr_q ? ~row_stb_n : (sr_req & accept);
    if (!sr_q || sr_go || row_stb_n) tick_d = '0;
    else tick_d = tick_q + 1'b1;
    if (sr_q && row_stb_n) rec_d = REC_W'(RECOV_CYC);
    else if (rec_q != '0) rec_d = rec_q - 1'b1;
    else rec_d = rec_q;
    cnt_d = go ? cnt_q + 1'b1 : cnt_q;
    row_d = go ? cnt_q : row_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      row_q   <= '0;
      tick_q  <= '0;
      rec_q   <= '0;
      sr_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      row_q   <= row_d;
      tick_q  <= tick_d;
      rec_q   <= rec_d;
      sr_q    <= sr_d;
      pulse_q <= go;
    end
  end

  assign busy  = sr_q | (rec_q != '0);
  assign sr_on = sr_q;
  assign pulse = pulse_q;
  assign row   = row_q;
endmodule

// File: rtl/dram_rfsq_window.sv
module dram_rfsq_window #(
  parameter int WIN_CYC = 1000,
  parameter int MIN_REF = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic pulse,
  output logic viol
);
  localparam int WIN_W = $clog2(WIN_CYC);
  localparam int CNT_W = $clog2(MIN_REF + 1);
  localparam logic [CNT_W:0] MIN_V = (CNT_W + 1)'(MIN_REF);

  logic [WIN_W-1:0] win_q, win_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             viol_q, viol_d;
  logic [CNT_W:0]   total;

  always_comb begin
    win_d  = win_q;
    cnt_d  = cnt_q;
    viol_d = viol_q;
    total  = {1'b0, cnt_q} + (CNT_W + 1)'(pulse);
    if (!run) begin
      win_d = '0;
      cnt_d = '0;
    end else if (win_q == WIN_W'(WIN_CYC - 1)) begin
      viol_d = viol_q | (total < MIN_V);
      win_d  = '0;
      cnt_d  = '0;
    end else begin
      win_d = win_q + 1'b1;
      if (pulse && cnt_q != CNT_W'(MIN_REF)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      cnt_q  <= '0;
      viol_q <= 1'b0;
    end else begin
      win_q  <= win_d;
      cnt_q  <= cnt_d;
      viol_q <= viol_d;
    end
  end

  assign viol = viol_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsq_pkg::*;
#(
  parameter int ROW_W     = 11,
  parameter int IDLE_CYC  = 200,
  parameter int INIT_REF  = 8,
  parameter int SR_TICK   = 16,
  parameter int RECOV_CYC = 10,
  parameter int WIN_CYC   = 100000,
  parameter int MIN_REF   = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_stb_n,
  input  logic             chip_sel_n,
  input  logic             write_sel,
  input  logic             refresh_n,
  input  logic             col_stb_n,
  input  logic             wr_en_n,
  input  logic [ROW_W-1:0] row_addr,
  output logic [ROW_W-1:0] refresh_row,
  output logic             refresh_pulse,
  output logic             self_refresh_on,
  output logic             ready,
  output logic             seq_error,
  output logic             window_viol,
  output logic             standby
);
  logic [1:0]  rst_q;
  logic        srst_n;
  strobe_cmd_t cmd;
  logic        stby_q, idle_done, busy, pin_ack, rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else rst_q <= {rst_q[0], 1'b1};
  end
  assign srst_n = rst_q[1];

  dram_rfsq_decode u_dec (
    .clk(clk), .rst_n(srst_n), .row_stb_n(row_stb_n), .chip_sel_n(chip_sel_n),
    .write_sel(write_sel), .refresh_n(refresh_n), .col_stb_n(col_stb_n),
    .wr_en_n(wr_en_n), .cmd(cmd), .stby_q(stby_q)
  );

  assign rd_ok = cmd.rd_req & idle_done & ~busy;

  dram_rfsq_init #(.ROW_W(ROW_W), .IDLE_CYC(IDLE_CYC), .INIT_REF(INIT_REF)) u_init (
    .clk(clk), .rst_n(srst_n), .row_stb_n(row_stb_n), .ref_ok(pin_ack), .rd_ok(rd_ok),
    .rd_req(cmd.rd_req), .wr_req(cmd.wr_req), .rd_row(row_addr),
    .idle_done(idle_done), .ready(ready), .seq_err(seq_error)
  );

  dram_rfsq_refresh #(.ROW_W(ROW_W), .SR_TICK(SR_TICK), .RECOV_CYC(RECOV_CYC)) u_ref (
    .clk(clk), .rst_n(srst_n), .row_stb_n(row_stb_n), .ref_req(cmd.ref_req),
    .sr_req(cmd.sr_req), .idle_done(idle_done), .pin_ack(pin_ack), .busy(busy),
    .sr_on(self_refresh_on), .pulse(refresh_pulse), .row(refresh_row)
  );

  dram_rfsq_window #(.WIN_CYC(WIN_CYC), .MIN_REF(MIN_REF)) u_win (
    .clk(clk), .rst_n(srst_n), .run(ready), .pulse(refresh_pulse), .viol(window_viol)
  );

  assign standby = stby_q & ~self_refresh_on;
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             row_stb_n,
  input logic [ROW_W-1:0] refresh_row,
  input logic             refresh_pulse,
  input logic             self_refresh_on,
  input logic             ready,
  input logic             seq_error,
  input logic             window_viol,
  input logic             standby
);
  logic [ROW_W-1:0] exp_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_row <= '0;
    else if (refresh_pulse) exp_row <= exp_row + 1'b1;
  end

  // R1, R3: each pulse carries the next counter row, wrapping at the width
  p_row_seq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_pulse |-> refresh_row == exp_row);

  // R4: self-refresh persists only while the row strobe stays low
  p_sr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (self_refresh_on && $past(self_refresh_on)) |-> !$past(row_stb_n));

  // R6: the exit cycle issues no refresh
  p_exit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(self_refresh_on) |-> !refresh_pulse);

  // R8: ready is sticky
  p_ready_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R9: error is sticky
  p_err_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_error |=> seq_error);

  // R10: the window check only runs once ready
  p_viol_after_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    window_viol |-> ready);

  // R11: no standby while self-refreshing
  p_standby_sr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    self_refresh_on |-> !standby);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .refresh_row(refresh_row),
  .refresh_pulse(refresh_pulse), .self_refresh_on(self_refresh_on), .ready(ready),
  .seq_error(seq_error), .window_viol(window_viol), .standby(standby)
);

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 4;
  localparam int IDLE_CYC = 20;
  localparam int SR_TICK = 8;
  localparam int RECOV_CYC = 6;
  localparam int WIN_CYC = 400;
  localparam int MIN_REF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_stb_n = 1'b1, chip_sel_n = 1'b0, write_sel = 1'b0;
  logic refresh_n = 1'b1, col_stb_n = 1'b1, wr_en_n = 1'b1;
  logic [ROW_W-1:0] row_addr = '0;
  logic [ROW_W-1:0] refresh_row;
  logic refresh_pulse, self_refresh_on, ready, seq_error, window_viol, standby;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int npulse = 0;
  int sr_cycles = 0;
  int sr_pulses = 0;
  logic [ROW_W-1:0] exp_row = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_refresh_seq #(
    .ROW_W(ROW_W), .IDLE_CYC(IDLE_CYC), .INIT_REF(8), .SR_TICK(SR_TICK),
    .RECOV_CYC(RECOV_CYC), .WIN_CYC(WIN_CYC), .MIN_REF(MIN_REF)
  ) i_dram_refresh_seq (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_sr_pulses(input int n);
    return (n > 0) ? (n - 1) / SR_TICK : 0;
  endfunction

  function automatic int pulses_for(input int kind);
    return (kind == 2) ? 1 : 0;
  endfunction

  // Pulse monitor: every pulse must carry the next counter row (R1, R3)
  always @(negedge clk) begin
    if (!rst_n) begin
      exp_row = '0;
      npulse = 0;
    end else begin
      if (refresh_pulse) begin
        chk("R1/R3 pulse row", int'(refresh_row), int'(exp_row));
        exp_row = exp_row + 1'b1;
        npulse++;
      end
      if (self_refresh_on) begin
        sr_cycles++;
        if (refresh_pulse) sr_pulses++;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    row_stb_n = 1'b1; chip_sel_n = 1'b0; write_sel = 1'b0;
    refresh_n = 1'b1; col_stb_n = 1'b1; wr_en_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic strobe(input logic cs, input logic ws, input logic rf,
                        input logic cal, input logic we, input logic [ROW_W-1:0] row);
    @(negedge clk);
    chip_sel_n = cs; write_sel = ws; refresh_n = rf; col_stb_n = cal;
    wr_en_n = we; row_addr = row; row_stb_n = 1'b0;
    @(negedge clk);
    row_stb_n = 1'b1; refresh_n = 1'b1; col_stb_n = 1'b1; wr_en_n = 1'b1;
    @(negedge clk);
    #1;
  endtask

  task automatic do_refresh(input logic cs);
    strobe(cs, 1'b0, 1'b0, 1'b1, 1'b1, '0);
  endtask

  task automatic do_read(input logic cs, input logic [ROW_W-1:0] row);
    strobe(cs, 1'b0, 1'b1, 1'b1, 1'b1, row);
  endtask

  task automatic do_write(input logic cs);
    strobe(cs, 1'b1, 1'b1, 1'b1, 1'b1, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    int r;
    r = $urandom(32'd7741);

    // Phase A: write in init phase sets the error
    do_reset();
    chk("R8 ready at reset", int'(ready), 0);
    chk("R9 error at reset", int'(seq_error), 0);
    chk("R4 sr at reset", int'(self_refresh_on), 0);
    chk("R10 viol at reset", int'(window_viol), 0);
    chk("R1 pulse at reset", int'(refresh_pulse), 0);
    repeat (IDLE_CYC + 6) @(negedge clk);
    do_write(1'b0);
    chk("R9 write before ready", int'(seq_error), 1);

    // Phase B: read during idle time sets the error
    do_reset();
    repeat (3) @(negedge clk);
    do_read(1'b0, 4'd1);
    chk("R9 read during idle", int'(seq_error), 1);

    // Phase C: full sequence
    do_reset();
    repeat (3) @(negedge clk);
    base = npulse;
    do_refresh(1'b0);
    chk("R7 refresh during idle ignored", npulse - base, 0);
    repeat (15) @(negedge clk);
    do_refresh(1'b0);
    chk("R7 idle count restarted", npulse - base, 0);
    repeat (IDLE_CYC + 5) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (i == 7) chk("R8 not ready after seven", int'(ready), 0);
      do_refresh(1'b0);
    end
    chk("R1 eight init refreshes", npulse - base, 8);
    chk("R8 no reads yet", int'(ready), 0);
    do_read(1'b0, 4'd5);
    do_read(1'b1, 4'd9);
    chk("R2 unselected read no progress", int'(ready), 0);
    do_read(1'b0, 4'd5);
    chk("R8 same row not enough", int'(ready), 0);
    do_read(1'b0, 4'd9);
    chk("R8 ready after distinct reads", int'(ready), 1);
    chk("R9 init reads no error", int'(seq_error), 0);
    do_write(1'b0);
    chk("R9 write after ready ok", int'(seq_error), 0);
    base = npulse;
    do_refresh(1'b1);
    chk("R2 refresh with chip select high", npulse - base, 1);

    // Random mix (R2, R11, R3 wrap via monitor)
    for (int it = 0; it < 40; it++) begin
      int kind;
      logic cs;
      kind = int'($urandom % 4);
      cs = logic'($urandom % 2);
      base = npulse;
      case (kind)
        0: do_read(cs, ROW_W'($urandom));
        1: do_write(cs);
        2: do_refresh(cs);
        default: repeat (int'($urandom % 6)) @(negedge clk);
      endcase
      if (kind != 3) chk("R11 standby follows chip select", int'(standby), int'(cs));
      chk("R2 random op pulses", npulse - base, pulses_for(kind));
      chip_sel_n = 1'b0;
      base = npulse;
      do_refresh(1'b0);
      chk("R1 random refresh", npulse - base, 1);
    end
    chk("R9 no error in random phase", int'(seq_error), 0);
    chk("R3 wrap reached", int'(npulse > (1 << ROW_W)), 1);

    // Self-refresh
    sr_cycles = 0;
    sr_pulses = 0;
    base = npulse;
    @(negedge clk);
    chip_sel_n = 1'b1; write_sel = 1'b1; refresh_n = 1'b1; wr_en_n = 1'b1;
    col_stb_n = 1'b0; row_stb_n = 1'b0;
    @(negedge clk);
    #1;
    chk("R4 self-refresh entered", int'(self_refresh_on), 1);
    chk("R11 standby low in self-refresh", int'(standby), 0);
    repeat (37) @(negedge clk);
    row_stb_n = 1'b1; chip_sel_n = 1'b0; col_stb_n = 1'b1; write_sel = 1'b0;
    @(negedge clk);
    #1;
    chk("R4 self-refresh exit", int'(self_refresh_on), 0);
    chk("R5 self-refresh pulse count", sr_pulses, exp_sr_pulses(sr_cycles));
    chk("R5 pulses not from pin", npulse - base, sr_pulses);
    base = npulse;
    do_refresh(1'b0);
    chk("R6 refresh in recovery ignored", npulse - base, 0);
    repeat (RECOV_CYC + 4) @(negedge clk);
    do_refresh(1'b0);
    chk("R6 refresh after recovery", npulse - base, 1);

    // Window monitor
    chk("R10 no violation while refreshed", int'(window_viol), 0);
    repeat (2 * WIN_CYC + 50) @(negedge clk);
    #1;
    chk("R10 starved window flagged", int'(window_viol), 1);

    finish_run();
  end
endmodule